// File: doc/BRIEF.md
# Multi-Channel Avionics Serial Word Register Interface

This block is the host-facing register file of a multi-channel controller for a two-wire avionics serial bus that carries 32-bit words. An 8-bit processor reaches every channel through a single 9-bit address. The address is split into a channel number, a direction bit, a register index and a byte lane. Each 32-bit word therefore crosses the 8-bit data port in four byte accesses.

On the transmit side, the first three bytes of a word are held in a staging register. Writing the top byte pushes the whole word into a per-channel transmit queue. On the receive side, the processor reads the word at the head of the queue byte by byte. Reading the top byte releases that word. Each channel also has a control byte, a status byte and, on the receive side, a four-entry label table. The table can restrict which incoming words are kept. The line encoder and decoder are outside this block. Each channel meets them through a plain valid/ready word port.

Top module: `a429_host_regs`

## Requirements
- R1: Address bits [8:5] give the channel, bit [4] selects transmit (1) or receive (0), bits [3:2] give the register index (0 data, 1 control, 2 status, 3 label table, which exists on receive only) and bits [1:0] give the byte lane, where lane 0 is bits [7:0] of the word. Accesses to a channel at or above N_CH, and to transmit index 3, read 0x00 and have no effect when written.
- R2: A read strobe loads `cpu_rdata` at that clock edge. The value holds until the next read strobe. A read and a write are never asserted together.
- R3: Transmit data writes to lanes 0 to 2 go into a staging register, which reads back on the same lanes (lane 3 reads 0x00). A write to lane 3 queues the word {byte written, staged bytes}. The oldest queued word appears on `tx_word` with `tx_valid` high, and it leaves the queue on a cycle where `tx_valid` and `tx_ready` are both high.
- R4: A lane-3 transmit commit made while that channel's transmit queue holds QUEUE_DEPTH words is dropped.
- R5: When transmit control bit 0 is set, bit 31 of each committed word is replaced so that the word holds an odd number of ones.
- R6: A receive data read returns the given lane of the word at the head of the receive queue. A read of lane 3 removes that word. An empty queue reads 0x00 and nothing is removed.
- R7: `rx_ready` is high while the channel's receive queue holds fewer than QUEUE_DEPTH words. A word offered with `rx_valid` and `rx_ready` both high is taken, and words come out in arrival order.
- R8: When receive control bit 0 is set, an offered word is kept only if its bits [7:0] equal one of the four label-table bytes. Other words are consumed and discarded.
- R9: Status lane 0 reads {6'b0, full, empty} for the selected direction's queue. Status lanes 1 to 3 read 0x00, and writes to status have no effect.
- R10: Control lane 0 is a read/write byte, and control lanes 1 to 3 read 0x00. The four receive label-table lanes are read/write bytes.
- R11: After reset, all queues are empty and all control, staging, label and read-data registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 9 | Packed channel/direction/index/lane address |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Registered read byte |
| tx_word | output | 32*N_CH | Head word of each transmit queue |
| tx_valid | output | N_CH | Transmit queue not empty |
| tx_ready | input | N_CH | Line side takes the transmit head word |
| rx_word | input | 32*N_CH | Word offered by each line decoder |
| rx_valid | input | N_CH | Receive word offered |
| rx_ready | output | N_CH | Receive queue has room |

## Verification
Each result is due at a fixed edge:
- A read strobe shows on `cpu_rdata` at the rising edge that samples it.
- A lane-3 commit raises `tx_valid` at that same edge.
- A line push that fills a queue drops `rx_ready` at its own edge.

Register writes take effect at the edge that samples them, so a read in the following cycle sees them. The bench drives inputs on falling edges and updates a behavioural queue model at each rising edge. It compares every output at the next falling edge, exactly one register stage after the stimulus.

// File: rtl/a429_pkg.sv
package a429_pkg;
   localparam int ADDR_W = 9;
   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      REG_DATA = 2'd0,
      REG_CTRL = 2'd1,
      REG_STAT = 2'd2,
      REG_LBL  = 2'd3
   } reg_idx_e;

   typedef struct packed {
      logic [3:0] chan;
      logic       is_tx;
      reg_idx_e   idx;
      logic [1:0] lane;
   } cpu_addr_t;

   // top bit that makes the whole word carry an odd count of ones
   function automatic logic odd_fill(input logic [30:0] d);
      return ~(^d);
   endfunction
endpackage

// File: rtl/a429_word_fifo.sv
module a429_word_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "a429_word_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   logic          push_ok, pop_ok;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end

   // R4: a full queue stays full when nothing leaves
   a_r4_full_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      full && push && !pop |=> full);
   // R7: an empty queue stays empty without a push
   a_r7_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
      empty && !push |=> empty);
endmodule

// File: rtl/a429_chan.sv
module a429_chan
   import a429_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sel,
   input  logic        is_tx,
   input  reg_idx_e    idx,
   input  logic [1:0]  lane,
   input  logic        wr,
   input  logic        rd,
   input  logic [7:0]  wdata,
   output logic [7:0]  rbyte,
   output logic [31:0] tx_word,
   output logic        tx_valid,
   input  logic        tx_ready,
   input  logic [31:0] rx_word,
   input  logic        rx_valid,
   output logic        rx_ready
);
   localparam int LBL_N = 4;

   logic             wr_hit, rd_hit;
   logic [23:0]      stage;
   logic [7:0]       tx_ctrl, rx_ctrl;
   logic [3:0][7:0]  lbl;
   logic [31:0]      raw_word, commit_word, rx_head;
   logic             tx_commit, tx_empty, tx_full;
   logic             rx_pop, rx_push, rx_empty, rx_full, lbl_hit, rx_keep;

   assign wr_hit    = sel && wr;
   assign rd_hit    = sel && rd;
   assign tx_commit = wr_hit && is_tx && idx == REG_DATA && lane == 2'd3;
   assign raw_word  = {wdata, stage};
   assign commit_word = tx_ctrl[0] ? {odd_fill(raw_word[30:0]), raw_word[30:0]}
                                   : raw_word;

   a429_word_fifo #(.W(32), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_commit), .din(commit_word),
      .pop(tx_valid && tx_ready), .dout(tx_word), .empty(tx_empty), .full(tx_full));
   assign tx_valid = !tx_empty;

   always_comb begin
      lbl_hit = 1'b0;
      for (int i = 0; i < LBL_N; i++)
         if (lbl[i] == rx_word[7:0]) lbl_hit = 1'b1;
   end
   assign rx_keep  = !rx_ctrl[0] || lbl_hit;
   assign rx_ready = !rx_full;
   assign rx_push  = rx_valid && rx_ready && rx_keep;
   assign rx_pop   = rd_hit && !is_tx && idx == REG_DATA && lane == 2'd3;

   a429_word_fifo #(.W(32), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
      .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage   <= '0;
         tx_ctrl <= '0;
         rx_ctrl <= '0;
         lbl     <= '0;
      end else if (wr_hit) begin
         if (is_tx) begin
            if (idx == REG_DATA) begin
               case (lane)
                  2'd0:    stage[7:0]   <= wdata;
                  2'd1:    stage[15:8]  <= wdata;
                  2'd2:    stage[23:16] <= wdata;
                  default: ;
               endcase
            end else if (idx == REG_CTRL && lane == 2'd0) begin
               tx_ctrl <= wdata;
            end
         end else begin
            if (idx == REG_CTRL && lane == 2'd0) rx_ctrl <= wdata;
            else if (idx == REG_LBL)             lbl[lane] <= wdata;
         end
      end
   end

   always_comb begin
      rbyte = 8'h00;
      if (is_tx) begin
         case (idx)
            REG_DATA: case (lane)
                         2'd0:    rbyte = stage[7:0];
                         2'd1:    rbyte = stage[15:8];
                         2'd2:    rbyte = stage[23:16];
                         default: rbyte = 8'h00;
                      endcase
            REG_CTRL: if (lane == 2'd0) rbyte = tx_ctrl;
            REG_STAT: if (lane == 2'd0) rbyte = {6'b0, tx_full, tx_empty};
            default:  rbyte = 8'h00;
         endcase
      end else begin
         case (idx)
            REG_DATA: if (!rx_empty) rbyte = rx_head[lane*8 +: 8];
            REG_CTRL: if (lane == 2'd0) rbyte = rx_ctrl;
            REG_STAT: if (lane == 2'd0) rbyte = {6'b0, rx_full, rx_empty};
            default:  rbyte = lbl[lane];
         endcase
      end
   end

   // R3: a commit always leaves a word waiting on the line side
   a_r3_commit_shows: assert property (@(posedge clk) disable iff (!rst_n)
      tx_commit |=> tx_valid);
   // R4: a full transmit queue stays full until the line side takes a word
   a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      tx_full && !(tx_valid && tx_ready) |=> tx_full);
endmodule

// File: rtl/a429_host_regs.sv
module a429_host_regs
   import a429_pkg::*;
#(
   parameter int N_CH        = 4,
   parameter int QUEUE_DEPTH = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [8:0]            cpu_addr,
   input  logic                  cpu_wr,
   input  logic                  cpu_rd,
   input  logic [7:0]            cpu_wdata,
   output logic [7:0]            cpu_rdata,
   output logic [32*N_CH-1:0]    tx_word,
   output logic [N_CH-1:0]       tx_valid,
   input  logic [N_CH-1:0]       tx_ready,
   input  logic [32*N_CH-1:0]    rx_word,
   input  logic [N_CH-1:0]       rx_valid,
   output logic [N_CH-1:0]       rx_ready
);
   initial begin
      if (N_CH < 1 || N_CH > 16)
         $fatal(1, "a429_host_regs: N_CH must be within 1..16");
   end

   cpu_addr_t              dec;
   logic [N_CH-1:0]        ch_sel;
   logic [N_CH-1:0][7:0]   ch_byte;
   logic [7:0]             rd_byte;

   assign dec = cpu_addr;

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      assign ch_sel[g] = (dec.chan == 4'(g));
      a429_chan #(.DEPTH(QUEUE_DEPTH)) u_chan (
         .clk(clk), .rst_n(rst_n), .sel(ch_sel[g]),
         .is_tx(dec.is_tx), .idx(dec.idx), .lane(dec.lane),
         .wr(cpu_wr), .rd(cpu_rd), .wdata(cpu_wdata), .rbyte(ch_byte[g]),
         .tx_word(tx_word[g*32 +: 32]), .tx_valid(tx_valid[g]), .tx_ready(tx_ready[g]),
         .rx_word(rx_word[g*32 +: 32]), .rx_valid(rx_valid[g]), .rx_ready(rx_ready[g]));
   end

   always_comb begin
      rd_byte = 8'h00;
      for (int i = 0; i < N_CH; i++)
         if (ch_sel[i]) rd_byte = rd_byte | ch_byte[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cpu_rdata <= 8'h00;
      else if (cpu_rd) cpu_rdata <= rd_byte;
   end

   // R2: read data only moves on a read strobe
   a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> $stable(cpu_rdata));
   // R2: strobes are exclusive
   a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_rd && cpu_wr));
   // R1: channels beyond the implemented count read zero
   a_r1_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd && (32'(cpu_addr[8:5]) >= N_CH) |=> cpu_rdata == 8'h00);
endmodule

// File: tb/a429_host_regs_tb.sv
module a429_host_regs_tb;
   localparam int NCH   = 4;
   localparam int DEPTH = 4;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [8:0]           cpu_addr = '0;
   logic                 cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [7:0]           cpu_wdata = '0;
   logic [7:0]           cpu_rdata;
   logic [32*NCH-1:0]    tx_word;
   logic [NCH-1:0]       tx_valid;
   logic [NCH-1:0]       tx_ready = '0;
   logic [32*NCH-1:0]    rx_word = '0;
   logic [NCH-1:0]       rx_valid = '0;
   logic [NCH-1:0]       rx_ready;

   int total = 0, bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   a429_host_regs #(.N_CH(NCH), .QUEUE_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tx_word(tx_word), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_word(rx_word), .rx_valid(rx_valid), .rx_ready(rx_ready));

   // behavioural reference state
   logic [31:0] txq [NCH][$];
   logic [31:0] rxq [NCH][$];
   logic [23:0] stage [NCH];
   logic [7:0]  txc [NCH];
   logic [7:0]  rxc [NCH];
   logic [7:0]  lbl [NCH][4];
   logic [7:0]  exp_rd;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_update();
      int ch, idx, lane;
      bit tx, hit, keep;
      int pre_tx[NCH], pre_rx[NCH];
      logic [31:0] w;
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            txq[c].delete(); rxq[c].delete();
            stage[c] = '0; txc[c] = '0; rxc[c] = '0;
            for (int i = 0; i < 4; i++) lbl[c][i] = '0;
         end
         exp_rd = '0;
         return;
      end
      ch = int'(cpu_addr[8:5]); tx = cpu_addr[4];
      idx = int'(cpu_addr[3:2]); lane = int'(cpu_addr[1:0]);
      hit = ch < NCH;
      for (int c = 0; c < NCH; c++) begin
         pre_tx[c] = txq[c].size();
         pre_rx[c] = rxq[c].size();
      end
      if (cpu_rd) begin
         exp_rd = '0;
         if (hit) begin
            if (tx) begin
               if (idx == 0 && lane < 3) exp_rd = stage[ch][lane*8 +: 8];
               else if (idx == 1 && lane == 0) exp_rd = txc[ch];
               else if (idx == 2 && lane == 0) exp_rd = {6'b0, pre_tx[ch] == DEPTH, pre_tx[ch] == 0};
            end else begin
               if (idx == 0 && pre_rx[ch] > 0) exp_rd = rxq[ch][0][lane*8 +: 8];
               else if (idx == 1 && lane == 0) exp_rd = rxc[ch];
               else if (idx == 2 && lane == 0) exp_rd = {6'b0, pre_rx[ch] == DEPTH, pre_rx[ch] == 0};
               else if (idx == 3) exp_rd = lbl[ch][lane];
            end
         end
      end
      for (int c = 0; c < NCH; c++) begin
         if (pre_tx[c] > 0 && tx_ready[c]) void'(txq[c].pop_front());
         w = rx_word[c*32 +: 32];
         keep = !rxc[c][0];
         for (int i = 0; i < 4; i++) if (lbl[c][i] == w[7:0]) keep = 1;
         if (rx_valid[c] && pre_rx[c] < DEPTH && keep) rxq[c].push_back(w);
      end
      if (hit && cpu_rd && !tx && idx == 0 && lane == 3 && pre_rx[ch] > 0)
         void'(rxq[ch].pop_front());
      if (hit && cpu_wr) begin
         if (tx) begin
            if (idx == 0 && lane < 3) stage[ch][lane*8 +: 8] = cpu_wdata;
            else if (idx == 0) begin
               w = {cpu_wdata, stage[ch]};
               if (txc[ch][0]) w[31] = ($countones(w[30:0]) % 2 == 0);
               if (pre_tx[ch] < DEPTH) txq[ch].push_back(w);
            end else if (idx == 1 && lane == 0) txc[ch] = cpu_wdata;
         end else begin
            if (idx == 1 && lane == 0) rxc[ch] = cpu_wdata;
            else if (idx == 3) lbl[ch][lane] = cpu_wdata;
         end
      end
   endtask

   task automatic compare();
      bit ok = (cpu_rdata == exp_rd);
      for (int c = 0; c < NCH; c++) begin
         if (tx_valid[c] != (txq[c].size() > 0)) ok = 0;
         if (txq[c].size() > 0 && tx_word[c*32 +: 32] != txq[c][0]) ok = 0;
         if (rx_ready[c] != (rxq[c].size() < DEPTH)) ok = 0;
      end
      // per-cycle model compare covers R2, R3 and R7
      chk(ok, "R2/R3/R7 model", {24'h0, cpu_rdata}, {24'h0, exp_rd});
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
   endtask

   function automatic logic [8:0] adr(input int ch, input bit tx, input int idx, input int lane);
      return {4'(ch), tx, 2'(idx), 2'(lane)};
   endfunction

   task automatic wr8(input int ch, input bit tx, input int idx, input int lane, input logic [7:0] d);
      cpu_addr = adr(ch, tx, idx, lane); cpu_wdata = d; cpu_wr = 1;
      step();
      cpu_wr = 0;
   endtask

   task automatic rd8(input int ch, input bit tx, input int idx, input int lane, output logic [7:0] got);
      cpu_addr = adr(ch, tx, idx, lane); cpu_rd = 1;
      step();
      cpu_rd = 0;
      got = cpu_rdata;
   endtask

   task automatic commit(input int ch, input logic [31:0] w);
      for (int l = 0; l < 4; l++) wr8(ch, 1, 0, l, w[l*8 +: 8]);
   endtask

   task automatic offer(input int ch, input logic [31:0] w);
      rx_valid[ch] = 1; rx_word[ch*32 +: 32] = w;
      step();
      rx_valid[ch] = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] g;
      repeat (3) step();
      rst_n = 1;
      step();
      // R11: reset state
      chk(cpu_rdata == 0 && tx_valid == 0 && rx_ready == '1, "R11 reset outputs",
          {cpu_rdata, 4'h0, tx_valid, 4'h0, rx_ready, 8'h0}, 32'h0000_0F00);
      rd8(0, 0, 2, 0, g); chk(g == 8'h01, "R11 rx status empty", g, 8'h01);

      // R3: staged bytes and commit
      commit(1, 32'h4433_2211);
      chk(tx_valid[1] && tx_word[63:32] == 32'h4433_2211, "R3 commit word", tx_word[63:32], 32'h4433_2211);
      rd8(1, 1, 0, 1, g); chk(g == 8'h22, "R3 stage readback", g, 8'h22);
      rd8(1, 1, 0, 3, g); chk(g == 8'h00, "R3 lane3 reads zero", g, 8'h00);

      // R4: fill and overflow
      commit(1, 32'h0000_0002);
      commit(1, 32'h0000_0003);
      commit(1, 32'h0000_0004);
      commit(1, 32'h0000_0005);
      rd8(1, 1, 2, 0, g); chk(g == 8'h02, "R4 tx status full", g, 8'h02);
      tx_ready[1] = 1;
      repeat (4) step();
      tx_ready[1] = 0;
      chk(tx_valid[1] == 0, "R4 dropped word absent", {31'h0, tx_valid[1]}, 0);

      // R5: odd parity fill
      wr8(0, 1, 1, 0, 8'h01);
      commit(0, 32'h0000_0000);
      commit(0, 32'hFFFF_FFFF);
      chk(tx_word[31:0] == 32'h8000_0000, "R5 parity zero word", tx_word[31:0], 32'h8000_0000);
      tx_ready[0] = 1; step(); tx_ready[0] = 0;
      chk(tx_word[31:0] == 32'h7FFF_FFFF, "R5 parity ones word", tx_word[31:0], 32'h7FFF_FFFF);
      tx_ready[0] = 1; step(); tx_ready[0] = 0;

      // R6: receive readout
      offer(2, 32'hA1B2_C3D4);
      offer(2, 32'h0102_0304);
      rd8(2, 0, 0, 0, g); chk(g == 8'hD4, "R6 lane0", g, 8'hD4);
      rd8(2, 0, 0, 2, g); chk(g == 8'hB2, "R6 lane2", g, 8'hB2);
      rd8(2, 0, 0, 3, g); chk(g == 8'hA1, "R6 lane3 pop", g, 8'hA1);
      rd8(2, 0, 0, 3, g); chk(g == 8'h01, "R6 second word", g, 8'h01);
      rd8(2, 0, 0, 3, g); chk(g == 8'h00, "R6 empty reads zero", g, 8'h00);

      // R7: receive full
      rx_valid[3] = 1;
      for (int i = 0; i < 5; i++) begin
         rx_word[127:96] = 32'(i + 16);
         step();
      end
      rx_valid[3] = 0;
      chk(rx_ready[3] == 0, "R7 ready low when full", {31'h0, rx_ready[3]}, 0);
      rd8(3, 0, 2, 0, g); chk(g == 8'h02, "R9 rx status full", g, 8'h02);
      rd8(3, 0, 0, 3, g); chk(g == 8'h00, "R7 first word order", g, 8'h00);
      rd8(3, 0, 0, 0, g); chk(g == 8'h11, "R7 second word order", g, 8'h11);

      // R8: label filter
      wr8(0, 0, 3, 0, 8'h10); wr8(0, 0, 3, 1, 8'h20);
      wr8(0, 0, 3, 2, 8'h30); wr8(0, 0, 3, 3, 8'h40);
      wr8(0, 0, 1, 0, 8'h01);
      offer(0, 32'hAA00_0020);
      offer(0, 32'hBB00_0055);
      offer(0, 32'hCC00_0040);
      rd8(0, 0, 0, 3, g); chk(g == 8'hAA, "R8 kept first", g, 8'hAA);
      rd8(0, 0, 0, 3, g); chk(g == 8'hCC, "R8 unmatched discarded", g, 8'hCC);
      rd8(0, 0, 0, 3, g); chk(g == 8'h00, "R8 queue empty", g, 8'h00);

      // R10: control and label table
      wr8(2, 0, 1, 1, 8'hFF);
      rd8(2, 0, 1, 1, g); chk(g == 8'h00, "R10 ctrl lane1 zero", g, 8'h00);
      rd8(0, 0, 1, 0, g); chk(g == 8'h01, "R10 ctrl lane0", g, 8'h01);
      rd8(0, 0, 3, 2, g); chk(g == 8'h30, "R10 label lane2", g, 8'h30);

      // R9: status write ignored
      wr8(2, 1, 2, 0, 8'hFF);
      rd8(2, 1, 2, 0, g); chk(g == 8'h01, "R9 status write ignored", g, 8'h01);
      rd8(2, 1, 2, 1, g); chk(g == 8'h00, "R9 status lane1 zero", g, 8'h00);

      // R1: unimplemented channel and transmit index 3
      wr8(5, 0, 1, 0, 8'h5A);
      rd8(5, 0, 1, 0, g); chk(g == 8'h00, "R1 unimplemented channel", g, 8'h00);
      wr8(0, 1, 3, 0, 8'h77);
      rd8(0, 1, 3, 0, g); chk(g == 8'h00, "R1 tx index3", g, 8'h00);
      commit(9, 32'h1234_5678);
      chk(tx_valid == 0, "R1 commit to absent channel", {28'h0, tx_valid}, 0);

      // R2: hold without a read
      step(); step();
      chk(cpu_rdata == 8'h00, "R2 rdata holds", {24'h0, cpu_rdata}, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule